// File: doc/BRIEF.md
# Partitioned threshold min-sum check node slice

This block is one slice of a min-sum check node in an LDPC decoder. The row's variable-to-check messages are spread over several slices that all work in the same cycle. Each slice sees only its own inputs. It exchanges exactly two wires with every other slice: a parity bit of its local signs, and a flag that says one of its local magnitudes is below a programmable threshold.

For each local input, the slice forms the smallest magnitude among the other local inputs. It finds the smallest and second-smallest values with a comparator tree. When any other slice reports a value below the threshold, the local result is capped at the threshold. This limits the error that comes from not seeing the true row minimum. The result is then scaled by a run-time selectable shift-and-add factor, and the outputs are registered.

The parity of the whole row is rebuilt from the local sign parity and the incoming sign bits. Each output sign is that row parity with the input's own sign removed.

Top module: `thr_minsum_slice`

## Requirements
- R1: `loc_flag` is combinational and is 1 exactly when at least one local magnitude is strictly smaller than `thresh`. A magnitude equal to `thresh` does not raise it.
- R2: `loc_sign` is combinational and equals the XOR of all bits of `in_sign`.
- R3: Local input i occupies `in_mag[i*W +: W]`. The pre-scale value for input i is the smallest magnitude among all other local inputs. With a unique minimum, the minimum's position gets the second-smallest value and every other input gets the minimum. With a tied minimum, every input gets the minimum.
- R4: When any bit of `peer_flag` is 1, the pre-scale value v of every input becomes min(v, `thresh`). When all `peer_flag` bits are 0, `thresh` has no effect on `out_mag`.
- R5: The scaling depends on `norm_sel`. With `norm_sel`=0 the output magnitude is c>>2. With `norm_sel`=1 it is (c>>2)+(c>>3). Each term is truncated separately. Here c is the value after R4.
- R6: `out_sign[i]` = `loc_sign` XOR (XOR of all `peer_sign` bits) XOR `in_sign[i]`.
- R7: `out_valid` is 1 in the cycle after a clock edge at which `in_valid` was 1, and 0 otherwise. `out_mag` and `out_sign` come from the inputs sampled at that same edge, including `thresh`, `peer_flag`, `peer_sign` and `norm_sel`.
- R8: An edge with `in_valid`=0 leaves `out_mag` and `out_sign` unchanged.
- R9: While `rst_n` is 0, `out_valid`, `out_mag` and `out_sign` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Local inputs are valid this cycle |
| in_sign | input | N | Sign bit of each local input message |
| in_mag | input | N*W | Magnitudes, input i at bits [i*W +: W] |
| thresh | input | W | Threshold value |
| peer_flag | input | P-1 | Below-threshold flags from the other slices |
| peer_sign | input | P-1 | Sign parity bits from the other slices |
| norm_sel | input | 1 | 0: scale 0.25, 1: scale 0.375 |
| loc_flag | output | 1 | This slice's below-threshold flag |
| loc_sign | output | 1 | This slice's sign parity |
| out_valid | output | 1 | Output messages are valid |
| out_sign | output | N | Output sign per local input |
| out_mag | output | N*W | Scaled output magnitudes, input i at [i*W +: W] |

## Verification
The hardest case to reach is a slice whose own minimum is below the threshold while its second-smallest value is not, under a raised peer flag. Only then does the minimum's own position get capped while the other inputs keep the local minimum. Random magnitudes hit this case only rarely, so directed vectors build it with one small value among large ones, both with and without peer flags. The bench also covers tied minimums and a minimum exactly equal to the threshold. The scaling shrinks small differences, so the directed magnitudes are chosen large enough that the capped and uncapped results give different outputs after the shift.

// File: rtl/thr_minsum_slice.sv
module thr_minsum_slice #(
  parameter int N = 4,
  parameter int W = 4,
  parameter int P = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [N-1:0]   in_sign,
  input  logic [N*W-1:0] in_mag,
  input  logic [W-1:0]   thresh,
  input  logic [P-2:0]   peer_flag,
  input  logic [P-2:0]   peer_sign,
  input  logic           norm_sel,
  output logic           loc_flag,
  output logic           loc_sign,
  output logic           out_valid,
  output logic [N-1:0]   out_sign,
  output logic [N*W-1:0] out_mag
);
  localparam int IW = $clog2(N);
  localparam int L  = 1 << IW;

  logic [L*W-1:0] pad;
  logic [W-1:0]   min1, min2;
  logic [IW-1:0]  min_idx;
  logic           peer_any, row_sign;
  logic [N-1:0]   nxt_sign;
  logic [N*W-1:0] nxt_mag;

  always_comb begin
    pad = '1;
    pad[N*W-1:0] = in_mag;
  end

  always_comb begin : tree
    logic [W-1:0]  a1 [L];
    logic [W-1:0]  a2 [L];
    logic [IW-1:0] ai [L];
    for (int i = 0; i < L; i++) begin
      a1[i] = pad[i*W +: W];
      a2[i] = '1;
      ai[i] = IW'(i);
    end
    for (int w = L / 2; w >= 1; w = w / 2) begin
      for (int k = 0; k < w; k++) begin
        if (a1[2*k] <= a1[2*k+1]) begin
          a2[k] = (a2[2*k] < a1[2*k+1]) ? a2[2*k] : a1[2*k+1];
          a1[k] = a1[2*k];
          ai[k] = ai[2*k];
        end else begin
          a2[k] = (a2[2*k+1] < a1[2*k]) ? a2[2*k+1] : a1[2*k];
          a1[k] = a1[2*k+1];
          ai[k] = ai[2*k+1];
        end
      end
    end
    min1    = a1[0];
    min2    = a2[0];
    min_idx = ai[0];
  end

  assign loc_flag = min1 < thresh;
  assign loc_sign = ^in_sign;
  assign peer_any = |peer_flag;
  assign row_sign = loc_sign ^ (^peer_sign);

  for (genvar i = 0; i < N; i++) begin : g_out
    logic [W-1:0] v, c;
    assign v = (min_idx == IW'(i)) ? min2 : min1;
    assign c = (peer_any && v >= thresh) ? thresh : v;
    assign nxt_mag[i*W +: W] = norm_sel ? W'((c >> 2) + (c >> 3)) : (c >> 2);
    assign nxt_sign[i] = row_sign ^ in_sign[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sign  <= '0;
      out_mag   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign <= nxt_sign;
        out_mag  <= nxt_mag;
      end
    end
  end
endmodule

module thr_minsum_slice_chk #(
  parameter int N = 4,
  parameter int W = 4,
  parameter int P = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [N-1:0]   in_sign,
  input logic [N*W-1:0] in_mag,
  input logic [W-1:0]   thresh,
  input logic [P-2:0]   peer_flag,
  input logic           loc_flag,
  input logic           out_valid,
  input logic [N-1:0]   out_sign,
  input logic [N*W-1:0] out_mag
);
  logic any_below;
  always_comb begin
    any_below = 1'b0;
    for (int i = 0; i < N; i++)
      if (in_mag[i*W +: W] < thresh) any_below = 1'b1;
  end

  p_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    loc_flag == any_below);

  p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_mag) && $stable(out_sign)));

  p_sign_rel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((out_sign ^ $past(in_sign)) == '0) || ((out_sign ^ $past(in_sign)) == '1)));

  for (genvar i = 0; i < N; i++) begin : g_cap
    p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (|peer_flag)) |=> (out_mag[i*W +: W] <= $past(thresh)));
  end
endmodule

bind thr_minsum_slice thr_minsum_slice_chk #(.N(N), .W(W), .P(P)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
  .in_mag(in_mag), .thresh(thresh), .peer_flag(peer_flag),
  .loc_flag(loc_flag), .out_valid(out_valid), .out_sign(out_sign),
  .out_mag(out_mag)
);

// File: tb/thr_minsum_slice_tb.sv
module thr_minsum_slice_tb_top;
  localparam int N = 4;
  localparam int W = 4;
  localparam int P = 4;
  localparam int CLK_P = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [N-1:0]   in_sign = '0;
  logic [N*W-1:0] in_mag = '0;
  logic [W-1:0]   thresh = '0;
  logic [P-2:0]   peer_flag = '0;
  logic [P-2:0]   peer_sign = '0;
  logic           norm_sel = 1'b0;
  logic           loc_flag, loc_sign, out_valid;
  logic [N-1:0]   out_sign;
  logic [N*W-1:0] out_mag;

  int checks = 0;
  int fails = 0;
  logic [N*W-1:0] exp_mag_q = '0;
  logic [N-1:0]   exp_sign_q = '0;

  always #(CLK_P/2) clk = ~clk;

  thr_minsum_slice #(.N(N), .W(W), .P(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_mag(in_mag), .thresh(thresh), .peer_flag(peer_flag),
    .peer_sign(peer_sign), .norm_sel(norm_sel), .loc_flag(loc_flag),
    .loc_sign(loc_sign), .out_valid(out_valid), .out_sign(out_sign),
    .out_mag(out_mag)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] model_mag(input logic [N*W-1:0] m, input logic [W-1:0] t,
                                               input logic [P-2:0] pf, input bit ns);
    logic [N*W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      logic [W-1:0] v, sh2, sh3;
      v = '1;
      for (int j = 0; j < N; j++)
        if (j != i && m[j*W +: W] < v) v = m[j*W +: W];
      if (pf != 0 && t < v) v = t;
      sh2 = v / 4;
      sh3 = v / 8;
      r[i*W +: W] = ns ? W'(sh2 + sh3) : sh2;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] model_sign(input logic [N-1:0] s, input logic [P-2:0] ps);
    logic p;
    p = 1'b0;
    for (int i = 0; i < N; i++) p = p ^ s[i];
    for (int i = 0; i < P-1; i++) p = p ^ ps[i];
    return s ^ {N{p}};
  endfunction

  function automatic bit model_flag(input logic [N*W-1:0] m, input logic [W-1:0] t);
    bit f;
    f = 1'b0;
    for (int i = 0; i < N; i++) if (m[i*W +: W] < t) f = 1'b1;
    return f;
  endfunction

  task automatic run_vec(input logic [N*W-1:0] m, input logic [N-1:0] s, input logic [W-1:0] t,
                         input logic [P-2:0] pf, input logic [P-2:0] ps, input bit ns,
                         input bit v, input string tag);
    in_mag = m; in_sign = s; thresh = t; peer_flag = pf; peer_sign = ps;
    norm_sel = ns; in_valid = v;
    #1;
    chk(loc_flag == model_flag(m, t), "R1", 64'(loc_flag), 64'(model_flag(m, t)));
    chk(loc_sign == ^s, "R2", 64'(loc_sign), 64'(^s));
    if (v) begin
      exp_mag_q  = model_mag(m, t, pf, ns);
      exp_sign_q = model_sign(s, ps);
    end
    @(posedge clk);
    #1;
    chk(out_valid == v, "R7", 64'(out_valid), 64'(v));
    chk(out_mag == exp_mag_q, v ? tag : "R8", 64'(out_mag), 64'(exp_mag_q));
    chk(out_sign == exp_sign_q, v ? "R6" : "R8", 64'(out_sign), 64'(exp_sign_q));
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    in_valid = 1'b1;
    in_mag = '1;
    in_sign = '1;
    repeat (2) @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R9", 64'(out_valid), 64'd0);
    chk(out_mag == '0, "R9", 64'(out_mag), 64'd0);
    chk(out_sign == '0, "R9", 64'(out_sign), 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;

    run_vec({4'd15, 4'd15, 4'd15, 4'd4}, 4'b0000, 4'd0, 3'b000, 3'b000, 1'b0, 1'b1, "R3");
    chk(out_mag[3:0] == 4'd3, "R3", 64'(out_mag[3:0]), 64'd3);
    chk(out_mag[7:4] == 4'd1, "R3", 64'(out_mag[7:4]), 64'd1);
    run_vec({4'd15, 4'd15, 4'd4, 4'd4}, 4'b0001, 4'd0, 3'b000, 3'b000, 1'b0, 1'b1, "R3");
    chk(out_mag == {4{4'd1}}, "R3", 64'(out_mag), 64'h1111);
    run_vec({4{4'd15}}, 4'b0000, 4'd8, 3'b010, 3'b000, 1'b0, 1'b1, "R4");
    chk(out_mag == {4{4'd2}}, "R4", 64'(out_mag), 64'h2222);
    run_vec({4{4'd15}}, 4'b0000, 4'd8, 3'b000, 3'b000, 1'b0, 1'b1, "R4");
    chk(out_mag == {4{4'd3}}, "R4", 64'(out_mag), 64'h3333);
    run_vec({4{4'd15}}, 4'b0000, 4'd0, 3'b100, 3'b000, 1'b1, 1'b1, "R4");
    chk(out_mag == '0, "R4", 64'(out_mag), 64'd0);
    run_vec({4'd15, 4'd15, 4'd15, 4'd3}, 4'b0000, 4'd8, 3'b001, 3'b000, 1'b0, 1'b1, "R4");
    chk(out_mag[3:0] == 4'd2, "R4", 64'(out_mag[3:0]), 64'd2);
    chk(out_mag[7:4] == 4'd0, "R4", 64'(out_mag[7:4]), 64'd0);
    run_vec({4{4'd15}}, 4'b0000, 4'd0, 3'b000, 3'b000, 1'b1, 1'b1, "R5");
    chk(out_mag == {4{4'd4}}, "R5", 64'(out_mag), 64'h4444);
    run_vec({4{4'd13}}, 4'b0000, 4'd0, 3'b000, 3'b000, 1'b1, 1'b1, "R5");
    chk(out_mag == {4{4'd4}}, "R5", 64'(out_mag), 64'h4444);
    run_vec({4'd9, 4'd9, 4'd9, 4'd6}, 4'b0000, 4'd6, 3'b000, 3'b000, 1'b0, 1'b1, "R1");
    chk(loc_flag == 1'b0, "R1", 64'(loc_flag), 64'd0);
    run_vec({4'd9, 4'd9, 4'd9, 4'd5}, 4'b0000, 4'd6, 3'b000, 3'b000, 1'b0, 1'b1, "R1");
    chk(loc_flag == 1'b1, "R1", 64'(loc_flag), 64'd1);
    run_vec({4'd9, 4'd9, 4'd9, 4'd9}, 4'b1011, 4'd6, 3'b000, 3'b110, 1'b0, 1'b1, "R6");
    chk(out_sign == 4'b0100, "R6", 64'(out_sign), 64'h4);
    run_vec({4'd1, 4'd2, 4'd3, 4'd4}, 4'b0101, 4'd9, 3'b111, 3'b101, 1'b1, 1'b0, "R8");

    for (int n = 0; n < 400; n++) begin
      bit vv;
      vv = ($urandom % 4) != 0;
      run_vec(16'($urandom), 4'($urandom), 4'($urandom), 3'($urandom % 2 == 0 ? 0 : $urandom),
              3'($urandom), 1'($urandom), vv, "R5");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule